// File: doc/BRIEF.md
# Falling-Voltage End-of-Charge Detector

This block decides when a nickel-based cell has reached full charge. The sign it looks for is a small drop in terminal voltage after a peak. An external voltage-to-frequency converter produces a pulse stream whose rate follows the sensed battery voltage. The block feeds that converter a divided sample clock, so each count is a ratio against the same timebase and does not depend on the clock frequency. It also sequences a periodic measurement cycle. At the start of every cycle an active-low gate output pauses the charge current. A settling phase follows, then a counting window in which converter pulses are accumulated into a saturating sample count.

Each accepted sample is compared with a running peak. A higher sample, even by one count, becomes the new peak. A sample at least two counts below the peak is a drop event. A sample equal to the peak or one count below it breaks any run of drops. Two drop events in consecutive samples raise a sticky end-of-charge flag. Detection is armed only after fast charge has been enabled, with the sensed voltage inside its valid range, for a set number of sample-clock ticks. Leaving that state clears all tracking at once.

Top module: `neg_slope_detect`

## Requirements
- R1: Each measurement cycle lasts PERIOD_TICKS sample-clock ticks, and one tick is CLK_DIV clocks. `gate_n` is low for the first PRESET_TICKS+CONVERT_TICKS ticks of each cycle. `conv_clk` is a square wave with a period of CLK_DIV clocks.
- R2: Pulses on `vfc_pulse` are counted only on clocks inside the counting window. The window is the CONVERT_TICKS ticks that follow the first PRESET_TICKS ticks of the gate-low time. The count appears on `sample_cnt` with a one-clock `sample_stb`, one clock after the window's last clock, in the same clock that `gate_n` returns high.
- R3: The sample count saturates at 2^COUNT_W-1.
- R4: The first accepted sample after a clear is loaded into `peak_cnt`.
- R5: A sample greater than the peak, by any amount, replaces the peak and resets the drop run. The peak never falls while tracking is active.
- R6: A sample at least DROP_MIN (2) counts below the peak is a drop event and leaves the peak unchanged. The second drop event in consecutive samples sets `eoc` in the same clock as that sample's `sample_stb`.
- R7: A sample equal to the peak or one count below it ends the drop run, so a later drop counts as the first again.
- R8: Once set, `eoc` stays high, and the peak no longer changes, until a clear. Later samples are still reported.
- R9: Tracking is armed START_TICKS ticks after `fast_en` and `win_ok` are both high. A counting window that opens before arming produces no sample.
- R10: Reset, or `fast_en` or `win_ok` low, clears `eoc`, `peak_cnt`, `sample_stb` and the drop run on the next clock, and restarts the arming delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oscillator) |
| rst | input | 1 | Synchronous active-high reset |
| fast_en | input | 1 | Charger is in fast-charge mode |
| win_ok | input | 1 | Sensed voltage is inside its valid range |
| vfc_pulse | input | 1 | One-clock pulses from the voltage-to-frequency converter |
| conv_clk | output | 1 | Divided sample clock for the converter |
| gate_n | output | 1 | Active-low charge-interrupt gate |
| sample_stb | output | 1 | One-clock strobe: a sample has been evaluated |
| sample_cnt | output | COUNT_W | Count of the latest evaluated sample |
| peak_cnt | output | COUNT_W | Running peak count |
| eoc | output | 1 | Sticky end-of-charge flag |

## Verification
`gate_n` falls in the first clock of a cycle, and a pulse is counted at the clock edge where it is high inside the window. The sample result, the peak update and any new `eoc` all arrive one clock after the window's final clock, together with `sample_stb`. A clear acts on the clock after `fast_en` or `win_ok` falls. The bench keys its comparisons to the strobe: a monitor pops the expected count, peak and flag when `sample_stb` is seen. Pulses are injected at least two clocks inside the window edges, so no check depends on a boundary clock. Clear results are read two clocks after the clearing input falls, and the no-sample windows before arming are checked by counting strobes over the whole cycle.

// File: rtl/nsd_pkg.sv
package nsd_pkg;

    // Phase of the measurement cycle
    typedef enum logic [1:0] {
        PH_SETTLE,
        PH_COUNT,
        PH_REST
    } phase_e;

    // Outcome of comparing one sample against the running peak
    typedef enum logic [1:0] {
        VD_FIRST,
        VD_RISE,
        VD_DROP,
        VD_NEAR
    } verdict_e;

    // Per-clock sequencer events shared with the datapath
    typedef struct packed {
        logic tick;   // sample-clock tick
        logic open;   // counting window is open this clock
        logic start;  // last clock before the window opens
        logic last;   // final clock of the window
    } seq_evt_t;

    function automatic verdict_e judge(input logic have_peak,
                                       input int unsigned smp,
                                       input int unsigned pk,
                                       input int unsigned drop_min);
        if (!have_peak)            return VD_FIRST;
        if (smp > pk)              return VD_RISE;
        if ((pk - smp) >= drop_min) return VD_DROP;
        return VD_NEAR;
    endfunction

endpackage

// File: rtl/nsd_seq.sv
module nsd_seq
    import nsd_pkg::*;
#(
    parameter int CLK_DIV       = 8,
    parameter int PRESET_TICKS  = 1045,
    parameter int CONVERT_TICKS = 2090,
    parameter int PERIOD_TICKS  = 131100
) (
    input  logic     clk,
    input  logic     rst,
    output seq_evt_t evt,
    output logic     gate_n,
    output logic     conv_clk
);
    localparam int GATE_TICKS = PRESET_TICKS + CONVERT_TICKS;
    localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int CW = $clog2(PERIOD_TICKS);

    localparam logic [DW-1:0] DIV_LAST  = DW'(CLK_DIV - 1);
    localparam logic [DW-1:0] DIV_HALF  = DW'(CLK_DIV / 2);
    localparam logic [CW-1:0] CYC_LAST  = CW'(PERIOD_TICKS - 1);
    localparam logic [CW-1:0] PRE_LAST  = CW'(PRESET_TICKS - 1);
    localparam logic [CW-1:0] PRE_END   = CW'(PRESET_TICKS);
    localparam logic [CW-1:0] GATE_LAST = CW'(GATE_TICKS - 1);
    localparam logic [CW-1:0] GATE_END  = CW'(GATE_TICKS);

    logic [DW-1:0] div_q;
    logic [CW-1:0] cyc_q;
    logic          tick;
    phase_e        phase;

    assign tick = (div_q == DIV_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            cyc_q <= '0;
        end else begin
            div_q <= tick ? '0 : div_q + 1'b1;
            if (tick) begin
                cyc_q <= (cyc_q == CYC_LAST) ? '0 : cyc_q + 1'b1;
            end
        end
    end

    always_comb begin
        if (cyc_q < PRE_END)       phase = PH_SETTLE;
        else if (cyc_q < GATE_END) phase = PH_COUNT;
        else                       phase = PH_REST;
    end

    always_comb begin
        evt.tick  = tick;
        evt.open  = (phase == PH_COUNT);
        evt.start = tick && (cyc_q == PRE_LAST);
        evt.last  = tick && (cyc_q == GATE_LAST);
    end

    assign gate_n   = (phase == PH_REST);
    assign conv_clk = (div_q < DIV_HALF);

endmodule

// File: rtl/nsd_win_cnt.sv
module nsd_win_cnt
    import nsd_pkg::*;
#(
    parameter int COUNT_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  seq_evt_t           evt,
    input  logic               pulse,
    output logic [COUNT_W-1:0] total
);
    localparam logic [COUNT_W-1:0] CNT_MAX = '1;

    logic [COUNT_W-1:0] acc_q;
    logic               hit;

    assign hit = evt.open && pulse;

    // Running total including this clock's pulse, saturating at the top
    always_comb begin
        if (hit && (acc_q != CNT_MAX)) total = acc_q + 1'b1;
        else                           total = acc_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr)    acc_q <= '0;
        else if (evt.last) acc_q <= '0;
        else               acc_q <= total;
    end

endmodule

// File: rtl/nsd_peak_trk.sv
module nsd_peak_trk
    import nsd_pkg::*;
#(
    parameter int COUNT_W     = 10,
    parameter int START_TICKS = 5700,
    parameter int DROP_MIN    = 2,
    parameter int EVENTS      = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  seq_evt_t           evt,
    input  logic [COUNT_W-1:0] smp,
    output logic               stb,
    output logic [COUNT_W-1:0] smp_q,
    output logic [COUNT_W-1:0] peak_q,
    output logic               eoc_q
);
    localparam int AW = $clog2(START_TICKS + 1);
    localparam int EW = $clog2(EVENTS + 1);
    localparam logic [AW-1:0] ARM_DONE = AW'(START_TICKS);
    localparam logic [EW-1:0] EV_LAST  = EW'(EVENTS - 1);

    logic [AW-1:0] arm_q;
    logic [EW-1:0] drops_q;
    logic          take_q;
    logic          have_q;
    logic          armed;
    logic          capture;
    verdict_e      vd;

    assign armed   = (arm_q == ARM_DONE);
    assign capture = en && evt.last && take_q;
    assign vd      = judge(have_q, 32'(smp), 32'(peak_q), DROP_MIN);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            arm_q   <= '0;
            take_q  <= 1'b0;
            have_q  <= 1'b0;
            drops_q <= '0;
            peak_q  <= '0;
            smp_q   <= '0;
            eoc_q   <= 1'b0;
            stb     <= 1'b0;
        end else begin
            stb <= capture;
            if (evt.tick && !armed) arm_q <= arm_q + 1'b1;

            // A window is sampled only if armed before it opens
            if (evt.start)     take_q <= armed;
            else if (evt.last) take_q <= 1'b0;

            if (capture) begin
                smp_q <= smp;
                if (!eoc_q) begin
                    unique case (vd)
                        VD_FIRST: begin
                            peak_q  <= smp;
                            have_q  <= 1'b1;
                            drops_q <= '0;
                        end
                        VD_RISE: begin
                            peak_q  <= smp;
                            drops_q <= '0;
                        end
                        VD_DROP: begin
                            if (drops_q == EV_LAST) eoc_q <= 1'b1;
                            else                    drops_q <= drops_q + 1'b1;
                        end
                        default: drops_q <= '0;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/neg_slope_detect.sv
module neg_slope_detect
    import nsd_pkg::*;
#(
    parameter int CLK_DIV       = 8,
    parameter int PRESET_TICKS  = 1045,
    parameter int CONVERT_TICKS = 2090,
    parameter int PERIOD_TICKS  = 131100,
    parameter int START_TICKS   = 5700,
    parameter int COUNT_W       = 10,
    parameter int DROP_MIN      = 2,
    parameter int EVENTS        = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fast_en,
    input  logic               win_ok,
    input  logic               vfc_pulse,
    output logic               conv_clk,
    output logic               gate_n,
    output logic               sample_stb,
    output logic [COUNT_W-1:0] sample_cnt,
    output logic [COUNT_W-1:0] peak_cnt,
    output logic               eoc
);
    seq_evt_t           evt;
    logic               track_en;
    logic [COUNT_W-1:0] win_total;

    assign track_en = fast_en && win_ok;

    nsd_seq #(
        .CLK_DIV      (CLK_DIV),
        .PRESET_TICKS (PRESET_TICKS),
        .CONVERT_TICKS(CONVERT_TICKS),
        .PERIOD_TICKS (PERIOD_TICKS)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .gate_n  (gate_n),
        .conv_clk(conv_clk)
    );

    nsd_win_cnt #(
        .COUNT_W(COUNT_W)
    ) u_win (
        .clk  (clk),
        .rst  (rst),
        .clr  (!track_en),
        .evt  (evt),
        .pulse(vfc_pulse),
        .total(win_total)
    );

    nsd_peak_trk #(
        .COUNT_W    (COUNT_W),
        .START_TICKS(START_TICKS),
        .DROP_MIN   (DROP_MIN),
        .EVENTS     (EVENTS)
    ) u_trk (
        .clk   (clk),
        .rst   (rst),
        .en    (track_en),
        .evt   (evt),
        .smp   (win_total),
        .stb   (sample_stb),
        .smp_q (sample_cnt),
        .peak_q(peak_cnt),
        .eoc_q (eoc)
    );

endmodule

// File: rtl/nsd_chk.sv
module nsd_chk #(
    parameter int COUNT_W = 10
) (
    input logic               clk,
    input logic               rst,
    input logic               fast_en,
    input logic               win_ok,
    input logic               gate_n,
    input logic               sample_stb,
    input logic [COUNT_W-1:0] sample_cnt,
    input logic [COUNT_W-1:0] peak_cnt,
    input logic               eoc
);
    AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (rst)
        !(fast_en && win_ok) |=> (!eoc && (peak_cnt == '0) && !sample_stb)); // R10

    AST_EOC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fast_en && win_ok && eoc) |=> eoc); // R8

    AST_PEAK_NO_FALL: assert property (@(posedge clk) disable iff (rst)
        (fast_en && win_ok) |=> (peak_cnt >= $past(peak_cnt))); // R5

    AST_SAMPLE_LE_PEAK: assert property (@(posedge clk) disable iff (rst)
        (sample_stb && !eoc) |-> (sample_cnt <= peak_cnt)); // R5

    AST_SAMPLE_AT_GATE_END: assert property (@(posedge clk) disable iff (rst)
        sample_stb |-> (gate_n && $past(!gate_n))); // R2

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> !sample_stb); // R2

    AST_EOC_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        $rose(eoc) |-> sample_stb); // R6

endmodule

bind neg_slope_detect nsd_chk #(.COUNT_W(COUNT_W)) u_nsd_chk (
    .clk       (clk),
    .rst       (rst),
    .fast_en   (fast_en),
    .win_ok    (win_ok),
    .gate_n    (gate_n),
    .sample_stb(sample_stb),
    .sample_cnt(sample_cnt),
    .peak_cnt  (peak_cnt),
    .eoc       (eoc)
);

// File: tb/neg_slope_detect_bench.sv
module neg_slope_detect_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 2;
    localparam int PRE   = 4;
    localparam int CONV  = 20;
    localparam int PER   = 40;
    localparam int START = 10;
    localparam int CW    = 4;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fast_en = 1'b0;
    logic          win_ok = 1'b0;
    logic          vfc_pulse = 1'b0;
    logic          conv_clk;
    logic          gate_n;
    logic          sample_stb;
    logic [CW-1:0] sample_cnt;
    logic [CW-1:0] peak_cnt;
    logic          eoc;

    always #(CLK_PERIOD / 2) clk = ~clk;

    neg_slope_detect #(
        .CLK_DIV(DIV), .PRESET_TICKS(PRE), .CONVERT_TICKS(CONV),
        .PERIOD_TICKS(PER), .START_TICKS(START), .COUNT_W(CW),
        .DROP_MIN(2), .EVENTS(2)
    ) u_neg_slope_detect (
        .clk(clk), .rst(rst), .fast_en(fast_en), .win_ok(win_ok),
        .vfc_pulse(vfc_pulse), .conv_clk(conv_clk), .gate_n(gate_n),
        .sample_stb(sample_stb), .sample_cnt(sample_cnt),
        .peak_cnt(peak_cnt), .eoc(eoc)
    );

    typedef struct {
        int    cnt;
        int    peak;
        int    flag;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   total = 0;
    int   bad = 0;
    int   stb_seen = 0;
    int   m_peak = 0;
    int   m_drops = 0;
    bit   m_have = 0;
    bit   m_eoc = 0;
    bit   finished = 0;

    task automatic check(input string tag, input string what, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    // Monitor: scoreboard pop on every sample strobe
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (sample_stb === 1'b1) begin
                stb_seen++;
                if (exp_q.size() == 0) begin
                    check("R9", "unexpected sample strobe", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(e.tag, "sample count", int'(sample_cnt), e.cnt);
                    check(e.tag, "peak count", int'(peak_cnt), e.peak);
                    check(e.tag, "end-of-charge flag", int'(eoc), e.flag);
                end
            end
        end
    end

    task automatic model_clear();
        m_peak = 0; m_drops = 0; m_have = 0; m_eoc = 0;
    endtask

    // Requirement model for one accepted sample
    task automatic push_expect(input int k, input string tag);
        exp_t e;
        int s;
        s = (k > CMAX) ? CMAX : k;
        if (!m_eoc) begin
            if (!m_have) begin
                m_peak = s; m_have = 1; m_drops = 0;
            end else if (s > m_peak) begin
                m_peak = s; m_drops = 0;
            end else if (m_peak - s >= 2) begin
                m_drops++;
                if (m_drops >= 2) m_eoc = 1;
            end else begin
                m_drops = 0;
            end
        end
        e.cnt = s; e.peak = m_peak; e.flag = int'(m_eoc); e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic wait_gate_fall();
        logic prev;
        prev = gate_n;
        forever begin
            @(negedge clk);
            if (prev === 1'b1 && gate_n === 1'b0) break;
            prev = gate_n;
        end
    endtask

    // Driver: one measurement cycle with k pulses well inside the window
    task automatic run_cycle(input int k, input string tag, input bit hold);
        wait_gate_fall();
        push_expect(k, tag);
        repeat (10) @(negedge clk);
        if (hold) begin
            vfc_pulse = 1'b1;
            repeat (k) @(negedge clk);
            vfc_pulse = 1'b0;
        end else begin
            for (int i = 0; i < k; i++) begin
                vfc_pulse = 1'b1;
                @(negedge clk);
                vfc_pulse = 1'b0;
                @(negedge clk);
            end
        end
    endtask

    // Pulses only in the settling phase and after the gate rises
    task automatic run_stray(input string tag);
        wait_gate_fall();
        push_expect(0, tag);
        vfc_pulse = 1'b1;
        repeat (3) @(negedge clk);
        vfc_pulse = 1'b0;
        while (gate_n !== 1'b1) @(negedge clk);
        vfc_pulse = 1'b1;
        repeat (4) @(negedge clk);
        vfc_pulse = 1'b0;
    endtask

    task automatic expect_no_sample(input string tag);
        int s0;
        s0 = stb_seen;
        repeat (60) @(negedge clk);
        check(tag, "strobes in unarmed cycle", stb_seen - s0, 0);
    endtask

    initial begin
        int lo;
        int per;
        int rises;
        logic pc;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "eoc after reset", int'(eoc), 0);
        check("R10", "peak after reset", int'(peak_cnt), 0);
        check("R10", "strobe after reset", int'(sample_stb), 0);

        // R1: gate width, cycle length and converter clock
        wait_gate_fall();
        lo = 1; rises = 0; pc = conv_clk;
        forever begin
            @(negedge clk);
            if (conv_clk && !pc) rises++;
            pc = conv_clk;
            if (gate_n === 1'b0) lo++;
            else break;
        end
        per = lo + 1;
        forever begin
            @(negedge clk);
            if (conv_clk && !pc) rises++;
            pc = conv_clk;
            if (gate_n === 1'b0) break;
            per++;
        end
        check("R1", "gate low clocks", lo, (PRE + CONV) * DIV);
        check("R1", "cycle clocks", per, PER * DIV);
        check("R1", "conv_clk rises per cycle", rises, PER);

        // R9: enable at a gate fall; that cycle is not sampled
        wait_gate_fall();
        fast_en = 1'b1; win_ok = 1'b1;
        model_clear();
        expect_no_sample("R9");

        run_cycle(8,  "R4", 0);
        run_cycle(10, "R5", 0);
        run_cycle(8,  "R6", 0);
        run_cycle(11, "R5", 0);
        run_cycle(9,  "R6", 0);
        run_cycle(10, "R7", 0);
        run_cycle(9,  "R6", 0);
        run_cycle(11, "R7", 0);
        run_cycle(9,  "R6", 0);
        run_cycle(5,  "R6", 0);
        run_cycle(14, "R8", 0);
        run_stray("R2");

        // R10: voltage leaves its window
        wait_gate_fall();
        win_ok = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10", "peak after window exit", int'(peak_cnt), 0);
        check("R10", "eoc after window exit", int'(eoc), 0);
        win_ok = 1'b1;
        model_clear();
        expect_no_sample("R9");

        run_cycle(20, "R3", 1);
        run_cycle(12, "R6", 0);

        // R10: fast mode dropped
        wait_gate_fall();
        fast_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10", "peak after fast mode off", int'(peak_cnt), 0);
        fast_en = 1'b1;
        model_clear();
        expect_no_sample("R9");

        run_cycle(3, "R4", 0);
        run_cycle(4, "R5", 0);

        repeat (100) @(negedge clk);
        check("R2", "samples still outstanding", exp_q.size(), 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog run did not finish actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule